// File: doc/BRIEF.md
# Buffered Serial Receiver with Fractional Baud Timing

This block receives asynchronous serial characters framed as one start bit, eight data bits and one stop bit, with no parity. The bit rate is set by a programmable phase increment. Each clock, the increment is added to a phase accumulator, and every carry out of the accumulator gives one oversampling tick, sixteen ticks per bit. The remainder stays in the accumulator, so the tick rate is exact on average and the sampling point stays near the centre of each bit, even at 921600 baud.

The serial line passes through a two-flop synchroniser. Each character that completes with a valid stop bit is written into a sixteen-entry queue. A host drains the queue through a simple read port: the data at the head, a valid bit, and a read strobe. If a character completes while the queue is full and no read frees a slot in that cycle, the character is lost and a sticky overrun flag is raised. A stop bit sampled low raises a sticky framing-error flag and the character is thrown away. One clear strobe resets both flags.

Top module: `uart_rx_buffered`

## Requirements
- R1: After reset, `rd_valid`, `ovr_flag` and `frm_err` are 0.
- R2: The oversampling tick is the carry out of an `ACC_W`-bit accumulator that adds `baud_inc` every clock, giving on average `baud_inc/2^ACC_W` ticks per clock. With a 100 MHz clock and `baud_inc` = 9664, characters sent at 921600 baud arrive intact.
- R3: Data bits are received least-significant bit first. The start bit is checked on its 8th tick and each later bit is sampled 16 ticks after the one before it. Any byte value, including 0x00, 0xFF, 0x55 and 0xAA, is delivered unchanged.
- R4: Accepted characters are delivered in arrival order, and the queue holds at most 16 of them.
- R5: A character that completes while the queue holds 16 entries and no read happens in that cycle is discarded, and `ovr_flag` goes to 1.
- R6: `ovr_flag` stays at 1 until `flag_clr` is pulsed. A pulse of `flag_clr` sets both `ovr_flag` and `frm_err` to 0.
- R7: If a read and a completed character fall in the same cycle while the queue is full, the character is stored and no overrun is flagged. A character that arrives after a read has freed a slot is also stored.
- R8: A low pulse on the line shorter than half a bit is not confirmed as a start bit and delivers no character.
- R9: A stop bit sampled low sets `frm_err` (sticky until `flag_clr`) and the character is not stored. Reception restarts only after the line has returned high.
- R10: While `rd_valid` is 1, `rd_data` shows the oldest character, and a cycle with `rd_en` high removes it. A `rd_en` pulse while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial input, idle high |
| baud_inc | input | ACC_W | Phase increment per clock (16x rate) |
| rd_en | input | 1 | Read strobe, pops the head when valid |
| flag_clr | input | 1 | Clears overrun and framing flags |
| rd_data | output | 8 | Oldest received character |
| rd_valid | output | 1 | Queue not empty |
| ovr_flag | output | 1 | Sticky overrun |
| frm_err | output | 1 | Sticky framing error |

## Verification
Characters are sent at 921600 baud with real-valued bit times that are not a whole number of clocks, so any error that builds up in the tick would show as corrupted bits late in a run of back-to-back frames. The byte values alternate between bit patterns (0x55, 0xAA), fill all ones or all zeros (0xFF, 0x00), and have one bit set at either end (0x01, 0x80). These separate a wrong bit order from an off-centre sample. A short low glitch tests start confirmation, and a low stop bit tests the framing path. A burst of seventeen frames, followed by one read and one more frame, separates a dropped character from one accepted at the full boundary.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_t;

  localparam int PHASE_MAX_W = 32;

  // Phase accumulator step; the top bit of the result is the carry.
  function automatic logic [PHASE_MAX_W:0] phase_step(
      input logic [PHASE_MAX_W-1:0] acc,
      input logic [PHASE_MAX_W-1:0] inc);
    return {1'b0, acc} + {1'b0, inc};
  endfunction

  // Circular pointer advance over a queue of given depth.
  function automatic int unsigned ptr_advance(input int unsigned ptr,
                                              input int unsigned depth);
    return (ptr + 1 == depth) ? 0 : ptr + 1;
  endfunction
endpackage

// File: rtl/rx_phase_tick.sv
module rx_phase_tick #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  output logic             tick
);
  import uart_rx_pkg::*;

  logic [ACC_W-1:0]     acc;
  logic [PHASE_MAX_W:0] sum;

  always_comb begin
    sum = phase_step(PHASE_MAX_W'(acc), PHASE_MAX_W'(inc));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  output logic              char_ok,
  output logic              char_bad,
  output logic [DATA_W-1:0] char_data
);
  import uart_rx_pkg::*;

  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  sub_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      sub_cnt  <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      char_ok  <= 1'b0;
      char_bad <= 1'b0;
    end else begin
      char_ok  <= 1'b0;
      char_bad <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (!line) begin
            state   <= RX_START;
            sub_cnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (sub_cnt == MID_CNT) begin
              sub_cnt <= '0;
              bit_idx <= '0;
              state   <= line ? RX_IDLE : RX_DATA;
            end else begin
              sub_cnt <= sub_cnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (sub_cnt == LAST_CNT) begin
              sub_cnt <= '0;
              shreg   <= {line, shreg[DATA_W-1:1]};
              if (bit_idx == LAST_BIT) state <= RX_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              sub_cnt <= sub_cnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (sub_cnt == LAST_CNT) begin
              sub_cnt <= '0;
              if (line) begin
                char_ok <= 1'b1;
                state   <= RX_IDLE;
              end else begin
                char_bad <= 1'b1;
                state    <= RX_BREAK;
              end
            end else begin
              sub_cnt <= sub_cnt + 1'b1;
            end
          end
        end
        RX_BREAK: begin
          if (line) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign char_data = shreg;
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     pop,
  output logic [DATA_W-1:0]        head,
  output logic                     full,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   count
);
  import uart_rx_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              do_wr, do_rd;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);
  assign do_rd = pop && !empty;
  assign do_wr = push && (!full || do_rd);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= AW'(ptr_advance(32'(wr_ptr), DEPTH));
      if (do_rd) rd_ptr <= AW'(ptr_advance(32'(rd_ptr), DEPTH));
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered #(
  parameter int ACC_W  = 16,
  parameter int OVS    = 16,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [ACC_W-1:0]  baud_inc,
  input  logic              rd_en,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ovr_flag,
  output logic              frm_err
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              tick;
  logic              rx_s;
  logic              push;
  logic              frame_bad;
  logic [DATA_W-1:0] char_data;
  logic              fifo_full;
  logic              fifo_empty;
  logic [CW-1:0]     fifo_count;
  logic              pop;
  logic              drop;

  rx_phase_tick #(.ACC_W(ACC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .inc(baud_inc), .tick(tick));

  rx_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s));

  rx_deframer #(.OVS(OVS), .DATA_W(DATA_W)) u_deframe (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_s),
    .char_ok(push), .char_bad(frame_bad), .char_data(char_data));

  rx_char_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(char_data),
    .pop(pop), .head(rd_data), .full(fifo_full), .empty(fifo_empty),
    .count(fifo_count));

  assign pop      = rd_en;
  assign rd_valid = !fifo_empty;
  assign drop     = push && fifo_full && !(rd_en && rd_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      if (drop)           ovr_flag <= 1'b1;
      else if (flag_clr)  ovr_flag <= 1'b0;
      if (frame_bad)      frm_err  <= 1'b1;
      else if (flag_clr)  frm_err  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push,
  input logic          frame_bad,
  input logic          pop,
  input logic          rd_valid,
  input logic          fifo_full,
  input logic          drop,
  input logic [CW-1:0] fifo_count,
  input logic          ovr_flag,
  input logic          frm_err,
  input logic          flag_clr
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && frame_bad));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= DEPTH_C);

  assert_drop_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr_flag);

  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !flag_clr) |=> ovr_flag);

  assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && fifo_full && !ovr_flag) |=>
      (fifo_count == DEPTH_C && !ovr_flag));

  assert_frame_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> frm_err);

  assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rd_valid && !push) |=> (fifo_count == '0));
endmodule

bind uart_rx_buffered uart_rx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .frame_bad(frame_bad),
  .pop(pop), .rd_valid(rd_valid), .fifo_full(fifo_full), .drop(drop),
  .fifo_count(fifo_count), .ovr_flag(ovr_flag), .frm_err(frm_err),
  .flag_clr(flag_clr));

// File: tb/test_uart_rx_buffered.sv
`timescale 1ns/1ps
module test_uart_rx_buffered;
  localparam real CLK_PERIOD = 10.0;
  localparam real BIT_NS     = 1.0e9 / 921600.0;
  localparam int  ACC_W      = 16;
  localparam int  DEPTH      = 16;
  localparam int  INC        = int'(921600.0 * 16.0 * 65536.0 / 100.0e6);

  logic       clk = 0;
  logic       rst_n = 0;
  logic       rxd = 1;
  logic       rd_en = 0;
  logic       flag_clr = 0;
  logic [7:0] rd_data;
  logic       rd_valid, ovr_flag, frm_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_en = 0;

  byte unsigned q[$];
  bit m_ovr = 0;
  bit m_frm = 0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  uart_rx_buffered #(.ACC_W(ACC_W), .DEPTH(DEPTH)) i_uart_rx_buffered (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_inc(ACC_W'(INC)),
    .rd_en(rd_en), .flag_clr(flag_clr), .rd_data(rd_data),
    .rd_valid(rd_valid), .ovr_flag(ovr_flag), .frm_err(frm_err));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Per-clock comparison against the behavioural model while the line is quiet.
  always @(posedge clk) begin
    #2;
    if (cmp_en && !done) begin
      chk(rd_valid == (q.size() > 0), "R4/R10", "rd_valid", rd_valid, q.size() > 0);
      if (q.size() > 0) chk(rd_data == q[0], "R3/R4", "rd_data", rd_data, q[0]);
      chk(ovr_flag == m_ovr, "R5/R6", "ovr_flag", ovr_flag, m_ovr);
      chk(frm_err == m_frm, "R9", "frm_err", frm_err, m_frm);
    end
  end

  task automatic send_char(input byte unsigned val, input bit stop);
    cmp_en = 0;
    rxd = 0;
    #(BIT_NS);
    for (int i = 0; i < 8; i++) begin
      rxd = val[i];
      #(BIT_NS);
    end
    rxd = stop;
    #(BIT_NS);
    rxd = 1;
    repeat (4) @(negedge clk);
    if (stop) begin
      if (q.size() < DEPTH) q.push_back(val);
      else m_ovr = 1;
    end else begin
      m_frm = 1;
    end
    cmp_en = 1;
  endtask

  task automatic read_one(input string tag);
    byte unsigned e;
    @(negedge clk);
    chk(rd_valid == 1, tag, "valid before read", rd_valid, 1);
    e = (q.size() > 0) ? q[0] : 8'h00;
    chk(rd_data == e, tag, "read data", rd_data, e);
    rd_en = 1;
    @(posedge clk);
    if (q.size() > 0) void'(q.pop_front());
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 1;
    @(posedge clk);
    m_ovr = 0;
    m_frm = 0;
    @(negedge clk);
    flag_clr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    byte unsigned pats[6] = '{8'h55, 8'hAA, 8'h00, 8'hFF, 8'h01, 8'h80};
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
    chk(ovr_flag == 0, "R1", "ovr_flag", ovr_flag, 0);
    chk(frm_err == 0, "R1", "frm_err", frm_err, 0);
    cmp_en = 1;

    // R10: read strobe on empty queue has no effect
    rd_en = 1;
    repeat (5) @(negedge clk);
    rd_en = 0;
    send_char(8'hA5, 1);
    chk(rd_valid == 1 && rd_data == 8'hA5, "R10", "single char after empty reads", rd_data, 8'hA5);
    read_one("R10");
    @(negedge clk);
    chk(rd_valid == 0, "R10", "empty after one read", rd_valid, 0);

    // R2/R3: back-to-back frames at 921600 baud, varied patterns
    foreach (pats[i]) send_char(pats[i], 1);
    chk(q.size() == 6, "R2", "model depth", q.size(), 6);
    foreach (pats[i]) read_one("R3");

    // R8: short glitch
    cmp_en = 0;
    rxd = 0;
    #(BIT_NS * 0.3);
    rxd = 1;
    #(BIT_NS * 12.0);
    @(negedge clk);
    cmp_en = 1;
    chk(rd_valid == 0, "R8", "no char from glitch", rd_valid, 0);

    // R9: low stop bit
    send_char(8'h5A, 0);
    #(BIT_NS * 2.0);
    @(negedge clk);
    chk(frm_err == 1, "R9", "frm_err set", frm_err, 1);
    chk(rd_valid == 0, "R9", "char discarded", rd_valid, 0);
    clear_flags();
    @(negedge clk);
    chk(frm_err == 0, "R9", "frm_err cleared", frm_err, 0);
    send_char(8'hC3, 1);
    read_one("R9");

    // R4/R5: fill, then one more
    for (int i = 0; i < DEPTH; i++) send_char(byte'(8'h10 + i), 1);
    @(negedge clk);
    chk(ovr_flag == 0, "R4", "no overrun at 16", ovr_flag, 0);
    send_char(8'hEE, 1);
    @(negedge clk);
    chk(ovr_flag == 1, "R5", "overrun on 17th", ovr_flag, 1);
    repeat (50) @(negedge clk);
    chk(ovr_flag == 1, "R6", "overrun sticky", ovr_flag, 1);
    clear_flags();
    @(negedge clk);
    chk(ovr_flag == 0, "R6", "overrun cleared", ovr_flag, 0);

    // R7: read frees one slot, next char accepted
    read_one("R7");
    send_char(8'h3C, 1);
    @(negedge clk);
    chk(ovr_flag == 0, "R7", "no overrun after freed slot", ovr_flag, 0);
    chk(q.size() == DEPTH, "R7", "model full again", q.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) read_one("R4");
    @(negedge clk);
    chk(rd_valid == 0, "R4", "drained", rd_valid, 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule